// File: doc/BRIEF.md
# Staged Clock and Voltage Transition Sequencer

This block moves a processor between two operating points. At the fast point the core clock is the PLL output, undivided, and the bus clock is half of it. At the slow point the core clock is a quarter of the PLL output and the bus clock runs at the core rate. The core clock comes from the PLL through a core divider, and the bus clock comes from the core clock through a bus divider. The bus clock must stay between a quarter and a half of the PLL rate at all times. For this reason a switch is never made in one step. Each switch walks three divider steps and passes through a core clock of half the PLL rate. The core voltage is set through a single-cycle write strobe to the power-management chip.

Going fast, the voltage is raised before any divider moves. Going slow, the voltage is lowered only after the last divider wait has expired. Every divider step is followed by a settling wait counted in microsecond tick pulses: 50, 50 and then 100 ticks. A request for the point already in effect does nothing. A request that arrives while a switch is running is dropped.

Top module: `opp_step_seq`

## Requirements
- R1: After reset the block is at the slow point: `core_div`=2 (PLL/4), `bus_div`=0 (bus equals core), `at_fast`=0, and `busy`, `done` and `pmu_wr` are all low.
- R2: A `req_valid` pulse is taken only when the block is idle and `req_fast` differs from `at_fast`. A request for the current point raises no `busy`, gives no strobe, changes no divider and gives no `done`.
- R3: A request that arrives while `busy` is high is ignored. The running switch finishes at its original target, and no further switch follows.
- R4: A switch to the fast point first strobes address 0x1E with data 0x17 and waits for `pmu_ack`. It then moves the divider pair (`core_div`,`bus_div`) through (1,0), (1,1) and (0,1), in that order.
- R5: A switch to the slow point moves the divider pair through (1,1), (1,0) and (2,0), in that order. Only after the last wait does it strobe address 0x1E with data 0x11, and it then waits for `pmu_ack`.
- R6: Each of the first two divider steps is held for 50 to 51 `us_tick` pulses before the next step. After the third step, 100 to 101 pulses pass before the completion or the voltage strobe.
- R7: The bus rate, PLL/2^(`core_div`+`bus_div`), is always between PLL/4 and PLL/2. `core_div` never exceeds 2.
- R8: `pmu_wr` is high for exactly one cycle per strobe. The sequencer moves no divider and gives no `done` until `pmu_ack` has been seen after the strobe.
- R9: `busy` is high from the cycle after an accepted request until completion. `done` pulses for one cycle as `busy` falls, and `at_fast` takes the new point in that same cycle. While idle, the dividers hold the values of the current point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_fast | input | 1 | Requested point: 1 fast, 0 slow |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| pmu_ack | input | 1 | Power-management write accepted |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle completion pulse |
| at_fast | output | 1 | Current operating point is fast |
| pmu_wr | output | 1 | One-cycle voltage write strobe |
| pmu_addr | output | 8 | Write address |
| pmu_data | output | 8 | Write data |
| core_div | output | 2 | Core divider code: clock is PLL/2^code |
| bus_div | output | 1 | Bus divider code: clock is core/2^code |

## Verification
The assertions assume three things about the inputs. Reset is high from time zero. `pmu_ack` is raised only in answer to a strobe. `us_tick` never stays high for more than one cycle. The stimulus follows all three: a responder gives one acknowledge per observed strobe after a set latency, and a generator pulses the tick every third cycle. Requests are single-cycle pulses applied on the falling clock edge. Some of them deliberately fall inside a running switch, and one switch is cut by reset halfway through its divider walk.

// File: rtl/opp_seq_pkg.sv
package opp_seq_pkg;

    // Core divider codes: core clock = PLL / 2^code
    localparam logic [1:0] CDIV_1 = 2'd0;
    localparam logic [1:0] CDIV_2 = 2'd1;
    localparam logic [1:0] CDIV_4 = 2'd2;

    // Bus divider codes: bus clock = core / 2^code
    localparam logic BDIV_1 = 1'b0;
    localparam logic BDIV_2 = 1'b1;

    // Voltage register and its two settings
    localparam logic [7:0] VREG_ADDR = 8'h1E;
    localparam logic [7:0] VCODE_HI  = 8'h17;
    localparam logic [7:0] VCODE_LO  = 8'h11;

    localparam int NUM_STEPS = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PMU_ISSUE,
        ST_PMU_WAIT,
        ST_STEP_LOAD,
        ST_STEP_WAIT
    } seq_state_e;

    typedef enum logic {
        TGT_CORE = 1'b0,
        TGT_BUS  = 1'b1
    } div_target_e;

    // One entry of the divider walk
    typedef struct packed {
        div_target_e target;
        logic [1:0]  code;
        logic        long_wait;
    } step_t;

    // Divider walk for each direction; every walk passes through core = PLL/2.
    function automatic step_t plan_step(input logic to_fast, input logic [1:0] idx);
        step_t s;
        case (idx)
            2'd0:    s = '{target: TGT_CORE, code: CDIV_2, long_wait: 1'b0};
            2'd1:    s = '{target: TGT_BUS,
                           code: {1'b0, (to_fast ? BDIV_2 : BDIV_1)},
                           long_wait: 1'b0};
            default: s = '{target: TGT_CORE,
                           code: (to_fast ? CDIV_1 : CDIV_4),
                           long_wait: 1'b1};
        endcase
        return s;
    endfunction

    // Bus rate must sit between PLL/4 and PLL/2
    function automatic logic bus_in_band(input logic [1:0] core, input logic bus);
        logic [2:0] total_shift;
        total_shift = {1'b0, core} + {2'b00, bus};
        return (core <= CDIV_4) && (total_shift >= 3'd1) && (total_shift <= 3'd2);
    endfunction

endpackage

// File: rtl/opp_delay_timer.sv
module opp_delay_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] remaining;

    // Expires on the tick that brings the count from one to zero
    assign expire = tick && (remaining == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (tick && (remaining != '0)) begin
            remaining <= remaining - W'(1);
        end
    end
endmodule

// File: rtl/opp_pmu_port.sv
module opp_pmu_port #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          wr,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    // Registered single-cycle strobe; address and data hold between writes
    always_ff @(posedge clk) begin
        if (rst) begin
            wr   <= 1'b0;
            addr <= '0;
            data <= '0;
        end else begin
            wr <= start;
            if (start) begin
                addr <= addr_in;
                data <= data_in;
            end
        end
    end
endmodule

// File: rtl/opp_div_bank.sv
module opp_div_bank
    import opp_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  step_t      step_in,
    output logic [1:0] core_div,
    output logic       bus_div
);
    // Divider settings move only when a step is loaded
    always_ff @(posedge clk) begin
        if (rst) begin
            core_div <= CDIV_4;
            bus_div  <= BDIV_1;
        end else if (load) begin
            if (step_in.target == TGT_BUS) begin
                bus_div <= step_in.code[0];
            end else begin
                core_div <= step_in.code;
            end
        end
    end
endmodule

// File: rtl/opp_step_seq.sv
module opp_step_seq
    import opp_seq_pkg::*;
#(
    parameter int SHORT_US = 50,
    parameter int LONG_US  = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_fast,
    input  logic       us_tick,
    input  logic       pmu_ack,
    output logic       busy,
    output logic       done,
    output logic       at_fast,
    output logic       pmu_wr,
    output logic [7:0] pmu_addr,
    output logic [7:0] pmu_data,
    output logic [1:0] core_div,
    output logic       bus_div
);
    localparam int DLY_W = $clog2(LONG_US + 1);
    localparam logic [1:0] LAST_IDX = 2'(NUM_STEPS - 1);

    seq_state_e state;
    logic [1:0] step_idx;
    logic       dir_fast;
    logic       cur_fast;
    logic       done_q;

    step_t             cur_step;
    logic              accept;
    logic              last_step;
    logic              timer_expire;
    logic              pmu_start;
    logic              div_load;
    logic [DLY_W-1:0]  wait_len;
    logic [7:0]        volt_code;

    assign accept    = (state == ST_IDLE) && req_valid && (req_fast != cur_fast);
    assign cur_step  = plan_step(dir_fast, step_idx);
    assign last_step = (step_idx == LAST_IDX);
    assign pmu_start = (state == ST_PMU_ISSUE);
    assign div_load  = (state == ST_STEP_LOAD);
    assign wait_len  = cur_step.long_wait ? DLY_W'(LONG_US) : DLY_W'(SHORT_US);
    assign volt_code = dir_fast ? VCODE_HI : VCODE_LO;

    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign at_fast = cur_fast;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            step_idx <= '0;
            dir_fast <= 1'b0;
            cur_fast <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        dir_fast <= req_fast;
                        step_idx <= '0;
                        // raising voltage precedes the clock walk
                        state    <= req_fast ? ST_PMU_ISSUE : ST_STEP_LOAD;
                    end
                end
                ST_PMU_ISSUE: state <= ST_PMU_WAIT;
                ST_PMU_WAIT: begin
                    if (pmu_ack) begin
                        if (dir_fast) begin
                            state <= ST_STEP_LOAD;
                        end else begin
                            state    <= ST_IDLE;
                            done_q   <= 1'b1;
                            cur_fast <= dir_fast;
                        end
                    end
                end
                ST_STEP_LOAD: state <= ST_STEP_WAIT;
                ST_STEP_WAIT: begin
                    if (timer_expire) begin
                        if (!last_step) begin
                            step_idx <= step_idx + 2'd1;
                            state    <= ST_STEP_LOAD;
                        end else if (dir_fast) begin
                            state    <= ST_IDLE;
                            done_q   <= 1'b1;
                            cur_fast <= dir_fast;
                        end else begin
                            // lowering voltage follows the clock walk
                            state <= ST_PMU_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    opp_delay_timer #(.W(DLY_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .load_val (wait_len),
        .tick     (us_tick),
        .expire   (timer_expire)
    );

    opp_div_bank u_divs (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .step_in  (cur_step),
        .core_div (core_div),
        .bus_div  (bus_div)
    );

    opp_pmu_port #(.AW(8), .DW(8)) u_pmu (
        .clk     (clk),
        .rst     (rst),
        .start   (pmu_start),
        .addr_in (VREG_ADDR),
        .data_in (volt_code),
        .wr      (pmu_wr),
        .addr    (pmu_addr),
        .data    (pmu_data)
    );
endmodule

// File: rtl/opp_seq_checker.sv
module opp_seq_checker
    import opp_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_fast,
    input logic       busy,
    input logic       done,
    input logic       at_fast,
    input logic       pmu_wr,
    input logic [7:0] pmu_addr,
    input logic [7:0] pmu_data,
    input logic [1:0] core_div,
    input logic       bus_div
);
    // R1: the cycle after reset shows the slow point and quiet outputs
    a_r1_reset_point: assert property (@(posedge clk)
        $past(rst) |-> (core_div == CDIV_4 && bus_div == BDIV_1 && !at_fast
                        && !busy && !done && !pmu_wr));

    // R2: a switch starts only on a request for the other point
    a_r2_accept_only_change: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(req_valid) && ($past(req_fast) != $past(at_fast))));

    // R3: the operating point flag does not move during a switch
    a_r3_point_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(at_fast));

    // R4: the raise write happens while the clocks are still slow
    a_r4_raise_first: assert property (@(posedge clk) disable iff (rst)
        (pmu_wr && pmu_data == VCODE_HI) |->
            (pmu_addr == VREG_ADDR && core_div == CDIV_4 && bus_div == BDIV_1));

    // R5: the lower write happens only once the clocks are already slow
    a_r5_lower_last: assert property (@(posedge clk) disable iff (rst)
        (pmu_wr && pmu_data == VCODE_LO) |->
            (pmu_addr == VREG_ADDR && core_div == CDIV_4 && bus_div == BDIV_1));

    // R7: bus rate stays inside the allowed band
    a_r7_bus_band: assert property (@(posedge clk) disable iff (rst)
        bus_in_band(core_div, bus_div));

    // R8: the strobe lasts a single cycle
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
        pmu_wr |=> !pmu_wr);

    // R9: done marks the falling edge of busy
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R9: when idle, the dividers match the reported point
    a_r9_idle_point: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (at_fast ? (core_div == CDIV_1 && bus_div == BDIV_2)
                           : (core_div == CDIV_4 && bus_div == BDIV_1)));
endmodule

bind opp_step_seq opp_seq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_fast  (req_fast),
    .busy      (busy),
    .done      (done),
    .at_fast   (at_fast),
    .pmu_wr    (pmu_wr),
    .pmu_addr  (pmu_addr),
    .pmu_data  (pmu_data),
    .core_div  (core_div),
    .bus_div   (bus_div)
);

// File: tb/opp_step_seq_bench.sv
module opp_step_seq_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_fast = 1'b0;
    logic us_tick = 1'b0;
    logic pmu_ack = 1'b0;
    logic busy, done, at_fast, pmu_wr, bus_div;
    logic [7:0] pmu_addr, pmu_data;
    logic [1:0] core_div;

    always #5 clk = ~clk;

    opp_step_seq u_opp_step_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_fast(req_fast),
        .us_tick(us_tick), .pmu_ack(pmu_ack), .busy(busy), .done(done),
        .at_fast(at_fast), .pmu_wr(pmu_wr), .pmu_addr(pmu_addr),
        .pmu_data(pmu_data), .core_div(core_div), .bus_div(bus_div)
    );

    int nchecks = 0;
    int nerr = 0;
    int cyc = 0;
    int ack_lat = 2;

    // vector: {request fast, action expected, fast point expected after}
    localparam logic [2:0] VEC [0:5] = '{3'b000, 3'b111, 3'b101, 3'b010, 3'b111, 3'b010};
    // expected walks from R4 and R5
    localparam logic [1:0] FAST_CORE [0:2] = '{2'd1, 2'd1, 2'd0};
    localparam logic       FAST_BUS  [0:2] = '{1'b0, 1'b1, 1'b1};
    localparam logic [1:0] SLOW_CORE [0:2] = '{2'd1, 2'd1, 2'd2};
    localparam logic       SLOW_BUS  [0:2] = '{1'b1, 1'b0, 1'b0};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
            $finish;
        end
    end

    // microsecond tick every third cycle
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        us_tick = (tdiv == 0);
    end

    // monitor (totals only grow; tests compare against snapshots)
    int chg_total = 0, pmu_total = 0, done_total = 0, busy_total = 0;
    int band_bad = 0, gap_bad = 0, pmu_long = 0, pmu_chg_at = 0;
    int tick_cnt = 0, k_in = 0;
    logic [1:0] prev_core = 2'd2;
    logic       prev_bus = 1'b0, prev_wr = 1'b0;
    logic [7:0] last_data = 8'h00, last_addr = 8'h00;
    logic [1:0] hist_core [0:15];
    logic       hist_bus  [0:15];

    always @(posedge clk) begin
        #1;
        if (rst) begin
            prev_core = core_div; prev_bus = bus_div;
            tick_cnt = 0; k_in = 0; prev_wr = 1'b0;
        end else begin
            int cm, bm;
            cm = 216 >> core_div;
            bm = cm >> bus_div;
            if (core_div > 2'd2 || bm < 54 || bm > 108) band_bad++;
            if (busy) busy_total++;
            if (core_div != prev_core || bus_div != prev_bus) begin
                if (k_in > 0 && (tick_cnt < 50 || tick_cnt > 51)) gap_bad++;
                hist_core[chg_total % 16] = core_div;
                hist_bus[chg_total % 16]  = bus_div;
                chg_total++; k_in++; tick_cnt = 0;
                prev_core = core_div; prev_bus = bus_div;
            end else if (us_tick) begin
                tick_cnt++;
            end
            if (pmu_wr) begin
                pmu_total++;
                pmu_chg_at = chg_total;
                last_data = pmu_data; last_addr = pmu_addr;
                if (prev_wr) pmu_long++;
                if (pmu_data == 8'h11 && (tick_cnt < 100 || tick_cnt > 101)) gap_bad++;
            end
            prev_wr = pmu_wr;
            if (done) begin
                done_total++;
                if (core_div == 2'd0 && (tick_cnt < 100 || tick_cnt > 101)) gap_bad++;
            end
            if (!busy) k_in = 0;
        end
    end

    // acknowledge responder: one ack per observed strobe after ack_lat cycles
    int served = 0, await_cnt = 0;
    always @(negedge clk) begin
        pmu_ack = 1'b0;
        if (served != pmu_total) begin
            if (await_cnt >= ack_lat) begin
                pmu_ack = 1'b1; served = pmu_total; await_cnt = 0;
            end else begin
                await_cnt++;
            end
        end
    end

    task automatic request(input logic f);
        @(negedge clk); req_valid = 1'b1; req_fast = f;
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #2;
            if (done) begin got = 1'b1; break; end
        end
    endtask

    task automatic check_point(input logic f, input string tag);
        chk(at_fast == f, {tag, " at_fast"}, at_fast, f);
        chk(core_div == (f ? 2'd0 : 2'd2), {tag, " core_div"}, core_div, f ? 0 : 2);
        chk(bus_div == f, {tag, " bus_div"}, bus_div, f);
    endtask

    initial begin
        bit got;
        int b_chg, b_pmu, b_done, b_busy, b_band, b_gap, b_long;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_point(1'b0, "R1");
        chk(!busy && !done && !pmu_wr, "R1 quiet outputs", {busy, done, pmu_wr}, 0);

        for (int v = 0; v < 6; v++) begin
            logic rf, act, ef;
            {rf, act, ef} = VEC[v];
            b_chg = chg_total; b_pmu = pmu_total; b_done = done_total; b_busy = busy_total;
            b_band = band_bad; b_gap = gap_bad; b_long = pmu_long;
            request(rf);
            if (act) begin
                wait_done(got);
                chk(got, "R9 done pulse seen", got, 1);
                chk(!busy, "R9 busy low at done", busy, 0);
                chk(chg_total - b_chg == 3, rf ? "R4 step count" : "R5 step count", chg_total - b_chg, 3);
                for (int j = 0; j < 3; j++) begin
                    logic [1:0] ec; logic eb;
                    ec = rf ? FAST_CORE[j] : SLOW_CORE[j];
                    eb = rf ? FAST_BUS[j]  : SLOW_BUS[j];
                    chk(hist_core[(b_chg + j) % 16] == ec && hist_bus[(b_chg + j) % 16] == eb,
                        rf ? "R4 walk order" : "R5 walk order",
                        {hist_core[(b_chg + j) % 16], hist_bus[(b_chg + j) % 16]}, {ec, eb});
                end
                chk(pmu_total - b_pmu == 1, "R8 one strobe", pmu_total - b_pmu, 1);
                chk(last_addr == 8'h1E, "R4 R5 pmu address", last_addr, 8'h1E);
                chk(last_data == (rf ? 8'h17 : 8'h11), rf ? "R4 pmu data" : "R5 pmu data",
                    last_data, rf ? 8'h17 : 8'h11);
                chk(pmu_chg_at - b_chg == (rf ? 0 : 3), rf ? "R4 voltage first" : "R5 voltage last",
                    pmu_chg_at - b_chg, rf ? 0 : 3);
                chk(gap_bad == b_gap, "R6 settling waits", gap_bad - b_gap, 0);
                chk(band_bad == b_band, "R7 bus band", band_bad - b_band, 0);
                chk(pmu_long == b_long, "R8 strobe width", pmu_long - b_long, 0);
                chk(done_total - b_done == 1, "R9 single done", done_total - b_done, 1);
            end else begin
                repeat (20) @(negedge clk);
                chk(busy_total == b_busy, "R2 no busy", busy_total - b_busy, 0);
                chk(chg_total == b_chg, "R2 no divider change", chg_total - b_chg, 0);
                chk(pmu_total == b_pmu, "R2 no strobe", pmu_total - b_pmu, 0);
                chk(done_total == b_done, "R2 no done", done_total - b_done, 0);
            end
            check_point(ef, "R9 final point");
        end

        // R3: requests during a switch are dropped
        b_chg = chg_total; b_pmu = pmu_total;
        request(1'b1);
        repeat (30) @(negedge clk);
        request(1'b0);
        repeat (10) @(negedge clk);
        request(1'b1);
        wait_done(got);
        chk(got, "R3 switch completes", got, 1);
        check_point(1'b1, "R3 original target");
        chk(chg_total - b_chg == 3 && pmu_total - b_pmu == 1, "R3 single walk",
            chg_total - b_chg, 3);
        b_busy = busy_total; b_chg = chg_total;
        repeat (40) @(negedge clk);
        chk(busy_total == b_busy && chg_total == b_chg, "R3 nothing after", busy_total - b_busy, 0);

        // return to slow for the acknowledge-hold tests
        request(1'b0);
        wait_done(got);
        check_point(1'b0, "R5 back to slow");

        // R8: a slow acknowledge holds the walk to fast
        ack_lat = 60;
        b_chg = chg_total; b_pmu = pmu_total;
        request(1'b1);
        for (int i = 0; i < 100 && pmu_total == b_pmu; i++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(chg_total == b_chg && busy, "R8 dividers wait for ack", chg_total - b_chg, 0);
        wait_done(got);
        chk(got && chg_total - b_chg == 3, "R8 walk after ack", chg_total - b_chg, 3);

        // R8: a slow acknowledge holds done going slow
        b_done = done_total; b_pmu = pmu_total;
        request(1'b0);
        for (int i = 0; i < 2000 && pmu_total == b_pmu; i++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(done_total == b_done && busy, "R8 done waits for ack", done_total - b_done, 0);
        wait_done(got);
        chk(got, "R8 done after ack", got, 1);
        check_point(1'b0, "R8 slow point");

        // R1: reset in the middle of a walk returns to the slow point
        ack_lat = 2;
        b_chg = chg_total;
        request(1'b1);
        for (int i = 0; i < 1000 && chg_total - b_chg < 2; i++) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_point(1'b0, "R1 mid-walk reset");
        chk(!busy && !done, "R1 idle after reset", busy, 0);
        request(1'b1);
        wait_done(got);
        chk(got, "R4 switch after reset", got, 1);
        check_point(1'b1, "R4 fast after reset");

        $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
        $finish;
    end
endmodule